// File: doc/BRIEF.md
# Character ROM Bank Selector

This block keeps eight character bank registers, loaded by CPU writes to a decoded register window, and turns every 13-bit video address in the range $0000-$1FFF into a character ROM address. The translation is purely combinational from the video address, so the video side sees a bank change on the cycle after the CPU write has been clocked in.

A 2-bit variant select chooses the slot layout. Variant 0 (and the unused code 3) splits video space into eight 1 KiB slots. Variant 2 uses the same eight slots and places a 2-bit outer segment number, provided by neighbouring program-bank logic, on top of the output, so the registers address within one 256 KiB segment. Variant 1 splits video space into four 2 KiB slots, fed by only four of the eight registers in a non-contiguous order.

Top module: `chr_bank_sel`

## Requirements
- R1: After reset every bank register is zero, so the output equals the video address bits that pass through with all bank and segment bits zero.
- R2: A write is accepted only when `cpu_wr_i` is high and (address AND $831F) lies in $8310-$8317. Address bits outside the mask are ignored, so $8B17 writes register 7 and $8210 writes nothing.
- R3: In variant 0 or 3, video bits 12:10 pick register 0-7 and the output is {2'b00, register, video[9:0]}.
- R4: In variant 2 the output is {outer_bank_i, register, video[9:0]}, the register picked as in R3.
- R5: In variant 1 video bits 12:11 values 0, 1, 2, 3 pick registers 0, 1, 6, 7 respectively, and the output is {1'b0, register, video[10:0]}.
- R6: Writes whose masked offset is $8-$F ($8318-$831F) change no register in any variant.
- R7: In variant 1, writes to offsets 2-5 change no register; the registers keep their values and show them when the variant changes to 0.
- R8: A register write takes effect at the clock edge that samples it; during the write cycle the output still reflects the previous value.
- R9: `outer_bank_i` has no effect on the output in variants 0, 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU write address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_wr_i | input | 1 | CPU write strobe, one cycle per write |
| ppu_addr_i | input | 13 | Video-side address |
| submap_i | input | 2 | Variant select: 0/3 eight 1 KiB slots, 1 four 2 KiB slots, 2 eight slots with outer segment |
| outer_bank_i | input | 2 | Outer 256 KiB segment, used in variant 2 |
| rom_addr_o | output | 20 | Character ROM address |

## Verification
The CPU can rewrite a bank register in the very cycle the video side fetches through the slot that register feeds. The bench provokes this by holding the video address on slot 1 while driving a write to offset 1, samples the output before the capturing edge and expects the old bank, then samples after the edge and expects the new one. The same collision is covered by a property relating each accepted write to the register contents one cycle later.

// File: rtl/chr_bank_pkg.sv
package chr_bank_pkg;

  typedef enum logic [1:0] {
    SUB_1K    = 2'd0,
    SUB_2K    = 2'd1,
    SUB_OUTER = 2'd2,
    SUB_ALT   = 2'd3
  } submap_e;

  localparam logic [15:0] REG_MASK  = 16'h831F;
  localparam logic [15:0] REG_MATCH = 16'h8310;

  // registers feeding the four 2 KiB slots, in slot order
  function automatic logic [2:0] slot2k_reg(input logic [1:0] slot);
    case (slot)
      2'd0:    return 3'd0;
      2'd1:    return 3'd1;
      2'd2:    return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic live_2k(input logic [2:0] idx);
    return (idx == 3'd0) || (idx == 3'd1) || (idx == 3'd6) || (idx == 3'd7);
  endfunction

endpackage

// File: rtl/chr_bank_wdec.sv
module chr_bank_wdec
  import chr_bank_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic [15:0]         cpu_addr_i,
  input  logic                cpu_wr_i,
  input  logic [1:0]          submap_i,
  output logic [NUM_REGS-1:0] we_o
);
  logic             win_hit;
  logic [3:0]       off;
  logic [IDX_W-1:0] idx;
  logic             live;

  assign off     = cpu_addr_i[3:0];
  assign idx     = off[IDX_W-1:0];
  assign win_hit = ((cpu_addr_i & REG_MASK & ~16'h000F) == REG_MATCH) && !off[3];

  always_comb begin
    live = win_hit;
    if (submap_e'(submap_i) == SUB_2K && !live_2k(off[2:0])) live = 1'b0;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_we
    assign we_o[i] = cpu_wr_i && live && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/chr_bank_regs.sv
module chr_bank_regs #(
  parameter int NUM_REGS = 8,
  parameter int BANK_W   = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NUM_REGS-1:0]                we_i,
  input  logic [BANK_W-1:0]                  data_i,
  output logic [NUM_REGS-1:0][BANK_W-1:0]    bank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_o <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (we_i[i]) bank_o[i] <= data_i;
      end
    end
  end
endmodule

// File: rtl/chr_bank_xlat.sv
module chr_bank_xlat
  import chr_bank_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int BANK_W   = 8,
  parameter int OUTER_W  = 2,
  localparam int PAGE_W  = 10,
  localparam int VA_W    = PAGE_W + $clog2(NUM_REGS),
  localparam int ROM_AW  = OUTER_W + BANK_W + PAGE_W
) (
  input  logic [NUM_REGS-1:0][BANK_W-1:0] bank_i,
  input  logic [VA_W-1:0]                 ppu_addr_i,
  input  logic [1:0]                      submap_i,
  input  logic [OUTER_W-1:0]              outer_bank_i,
  output logic [ROM_AW-1:0]               rom_addr_o
);
  logic [BANK_W-1:0] sel_1k;
  logic [BANK_W-1:0] sel_2k;

  assign sel_1k = bank_i[ppu_addr_i[VA_W-1:PAGE_W]];
  assign sel_2k = bank_i[slot2k_reg(ppu_addr_i[VA_W-1:VA_W-2])];

  always_comb begin
    case (submap_e'(submap_i))
      SUB_2K:    rom_addr_o = {{(OUTER_W-1){1'b0}}, sel_2k, ppu_addr_i[PAGE_W:0]};
      SUB_OUTER: rom_addr_o = {outer_bank_i, sel_1k, ppu_addr_i[PAGE_W-1:0]};
      default:   rom_addr_o = {{OUTER_W{1'b0}}, sel_1k, ppu_addr_i[PAGE_W-1:0]};
    endcase
  end
endmodule

// File: rtl/chr_bank_sel.sv
module chr_bank_sel #(
  parameter int NUM_REGS = 8,
  parameter int BANK_W   = 8,
  parameter int OUTER_W  = 2,
  localparam int PAGE_W  = 10,
  localparam int VA_W    = PAGE_W + $clog2(NUM_REGS),
  localparam int ROM_AW  = OUTER_W + BANK_W + PAGE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [15:0]        cpu_addr_i,
  input  logic [BANK_W-1:0]  cpu_data_i,
  input  logic               cpu_wr_i,
  input  logic [VA_W-1:0]    ppu_addr_i,
  input  logic [1:0]         submap_i,
  input  logic [OUTER_W-1:0] outer_bank_i,
  output logic [ROM_AW-1:0]  rom_addr_o
);
  logic [NUM_REGS-1:0]             reg_we;
  logic [NUM_REGS-1:0][BANK_W-1:0] bank_q;

  chr_bank_wdec #(.NUM_REGS(NUM_REGS)) u_wdec (
    .cpu_addr_i (cpu_addr_i),
    .cpu_wr_i   (cpu_wr_i),
    .submap_i   (submap_i),
    .we_o       (reg_we)
  );

  chr_bank_regs #(.NUM_REGS(NUM_REGS), .BANK_W(BANK_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we),
    .data_i (cpu_data_i),
    .bank_o (bank_q)
  );

  chr_bank_xlat #(.NUM_REGS(NUM_REGS), .BANK_W(BANK_W), .OUTER_W(OUTER_W)) u_xlat (
    .bank_i       (bank_q),
    .ppu_addr_i   (ppu_addr_i),
    .submap_i     (submap_i),
    .outer_bank_i (outer_bank_i),
    .rom_addr_o   (rom_addr_o)
  );
endmodule

// File: rtl/chr_bank_sel_chk.sv
module chr_bank_sel_chk #(
  parameter int NUM_REGS = 8,
  parameter int BANK_W   = 8,
  parameter int OUTER_W  = 2,
  parameter int VA_W     = 13,
  parameter int ROM_AW   = 20
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic [15:0]                      cpu_addr_i,
  input logic [BANK_W-1:0]                cpu_data_i,
  input logic                             cpu_wr_i,
  input logic [VA_W-1:0]                  ppu_addr_i,
  input logic [1:0]                       submap_i,
  input logic [OUTER_W-1:0]               outer_bank_i,
  input logic [ROM_AW-1:0]                rom_addr_o,
  input logic [NUM_REGS-1:0][BANK_W-1:0]  bank_q
);
  logic win;
  logic live;
  assign win  = (cpu_addr_i[15] && cpu_addr_i[9:8] == 2'b11 && cpu_addr_i[4]);
  assign live = win && !cpu_addr_i[3] &&
                !(submap_i == 2'd1 && cpu_addr_i[2:0] inside {3'd2, 3'd3, 3'd4, 3'd5});

  // R2
  no_stray_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_wr_i && win) |=> $stable(bank_q));

  // R6
  high_off_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && win && cpu_addr_i[3]) |=> $stable(bank_q));

  // R7
  dead_2k_regs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && win && !cpu_addr_i[3] && submap_i == 2'd1 &&
     cpu_addr_i[2:0] inside {3'd2, 3'd3, 3'd4, 3'd5}) |=> $stable(bank_q));

  // R8
  wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && live) |=> bank_q[$past(cpu_addr_i[2:0])] == $past(cpu_data_i));

  // R3
  page_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_addr_o[9:0] == ppu_addr_i[9:0]);

  // R4
  outer_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (submap_i == 2'd2) |-> rom_addr_o[ROM_AW-1 -: OUTER_W] == outer_bank_i);

  // R9
  no_outer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (submap_i != 2'd2) |-> rom_addr_o[ROM_AW-1] == 1'b0);
endmodule

bind chr_bank_sel chr_bank_sel_chk #(
  .NUM_REGS(NUM_REGS), .BANK_W(BANK_W), .OUTER_W(OUTER_W), .VA_W(VA_W), .ROM_AW(ROM_AW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cpu_addr_i   (cpu_addr_i),
  .cpu_data_i   (cpu_data_i),
  .cpu_wr_i     (cpu_wr_i),
  .ppu_addr_i   (ppu_addr_i),
  .submap_i     (submap_i),
  .outer_bank_i (outer_bank_i),
  .rom_addr_o   (rom_addr_o),
  .bank_q       (bank_q)
);

// File: tb/chr_bank_sel_tb_top.sv
module chr_bank_sel_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic [7:0]  cpu_data_i = '0;
  logic        cpu_wr_i = 1'b0;
  logic [12:0] ppu_addr_i = '0;
  logic [1:0]  submap_i = '0;
  logic [1:0]  outer_bank_i = '0;
  logic [19:0] rom_addr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  chr_bank_sel dut_i (.*);

  // {submap, outer, video addr, expected}; regs preloaded 11,22,...,88
  localparam int NV = 10;
  localparam logic [36:0] VEC [NV] = '{
    {2'd0, 2'd3, 13'h0000, 20'h04400},  // R3 R9
    {2'd0, 2'd0, 13'h1FFF, 20'h223FF},  // R3
    {2'd0, 2'd1, 13'h0A05, 20'h0CE05},  // R3
    {2'd2, 2'd2, 13'h1400, 20'h99800},  // R4
    {2'd2, 2'd1, 13'h07FF, 20'h48BFF},  // R4
    {2'd1, 2'd3, 13'h0000, 20'h08800},  // R5 R9
    {2'd1, 2'd0, 13'h0FFF, 20'h117FF},  // R5
    {2'd1, 2'd2, 13'h1000, 20'h3B800},  // R5
    {2'd1, 2'd1, 13'h1ABC, 20'h442BC},  // R5
    {2'd3, 2'd3, 13'h1C01, 20'h22001}   // R3 R9
  };

  task automatic check(input string req, input logic [19:0] exp);
    n_chk++;
    if (rom_addr_o !== exp) begin
      n_bad++;
      $display("FAIL %s: rom_addr_o=%05h expected %05h", req, rom_addr_o, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_data_i = d; cpu_wr_i = 1'b1;
    @(negedge clk_i);
    cpu_wr_i = 1'b0;
  endtask

  task automatic look(input logic [1:0] s, input logic [1:0] o, input logic [12:0] va);
    @(negedge clk_i);
    submap_i = s; outer_bank_i = o; ppu_addr_i = va;
    #1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    look(2'd0, 2'd3, 13'h1234);
    check("R1 reset", 20'h00234);
    rst_ni = 1'b1;
    look(2'd2, 2'd3, 13'h1FFF);
    check("R1 reset outer", 20'hC03FF);

    for (int i = 0; i < 8; i++) cpu_write(16'h8310 + 16'(i), 8'(8'h11 * (i + 1)));
    cpu_write(16'h8318, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      look(VEC[i][36:35], VEC[i][34:33], VEC[i][32:20]);
      check($sformatf("R3/R4/R5 vector %0d", i), VEC[i][19:0]);
    end

    // R6: offsets 8-F leave every slot alone
    cpu_write(16'h831F, 8'hEE);
    cpu_write(16'h8318, 8'hEE);
    look(2'd0, 2'd0, 13'h0000); check("R6 slot0", 20'h04400);
    look(2'd0, 2'd0, 13'h1C00); check("R6 slot7", 20'h22000);

    // R2: address outside window, then a mirrored alias
    cpu_write(16'h8210, 8'hEE);
    look(2'd0, 2'd0, 13'h0000); check("R2 no match", 20'h04400);
    cpu_write(16'h8B17, 8'h5A);
    look(2'd0, 2'd0, 13'h1C00); check("R2 mirror", 20'h16800);

    // R7: dead registers in 2 KiB mode, seen after switching to 1 KiB
    submap_i = 2'd1;
    cpu_write(16'h8312, 8'hAB);
    cpu_write(16'h8315, 8'hAB);
    look(2'd0, 2'd0, 13'h0800); check("R7 reg2", 20'h0CC00);
    look(2'd0, 2'd0, 13'h1400); check("R7 reg5", 20'h19800);

    // R8: write and fetch on the same slot in the same cycle
    look(2'd0, 2'd0, 13'h0400);
    @(negedge clk_i);
    cpu_addr_i = 16'h8311; cpu_data_i = 8'h99; cpu_wr_i = 1'b1;
    #1 check("R8 old value in write cycle", 20'h08800);
    @(negedge clk_i);
    cpu_wr_i = 1'b0;
    #1 check("R8 new value after edge", 20'h26400);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule